// File: doc/BRIEF.md
# Banked Interrupt Mask and Pending Register Block

This block gathers 72 level interrupt sources: eight basic sources and two banks of 32 peripheral sources. Each source has its own mask bit. Software never has to read a mask, change it and write it back. Each group has a set-only address and a clear-only address. A 1 in the write data enables or disables that bit, and a 0 leaves it as it is.

A source is pending while it is asserted and enabled. Pending is not latched, so it follows the source level. Software can read each bank's pending word in full. It can also read a summary word. The summary holds the basic sources, one flag per bank and a fixed set of shortcut copies of single bank sources, so a handler can often find its source with one read. The CPU interrupt line is high whenever any summary bit is set.

The register port is a plain 32-bit bus. It has a byte address, a write strobe and write data. Read data is combinational from the address. Mask writes take effect at the clock edge that samples the write strobe.

Top module: `irq_bank_regs`

## Requirements
- R1: The source vector holds the basic sources in bits 7:0, bank A source i in bit 8+i and bank B source i in bit 40+i. The bank A pending word at byte offset 0x04 and the bank B pending word at 0x08 read, bit i, as source i AND its enable, and they follow the source level in the same cycle.
- R2: A write of 1s to a set address enables those bits: 0x18 for basic, 0x10 for bank A, 0x14 for bank B. Bits written as 0 keep their state.
- R3: A write of 1s to a clear address disables those bits: 0x24 for basic, 0x1C for bank A, 0x20 for bank B. Bits written as 0 keep their state.
- R4: The set addresses read back the current enables. The clear addresses and 0x0C read as zero. Writes to 0x00, 0x04, 0x08 and 0x0C change no enable.
- R5: Summary word (offset 0x00) bits 7:0 are the enabled-and-asserted basic sources.
- R6: Summary bit 8 is the OR of bank A pending bits other than 7, 9, 10, 18 and 19. Summary bit 9 is the OR of bank B pending bits other than 21, 22, 23, 24, 25 and 30.
- R7: Summary bits 10 to 14 copy bank A pending bits 7, 9, 10, 18 and 19 in that order. Summary bits 15 to 20 copy bank B pending bits 21, 22, 23, 24, 25 and 30 in that order.
- R8: Summary bits 31:21 read as zero.
- R9: cpu_irq is the OR of all summary bits.
- R10: After reset every enable is 0, so cpu_irq is 0 and every pending word is 0 whatever the sources do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| src_in | input | 72 | Level interrupt sources |
| cpu_irq | output | 1 | Level interrupt request to the CPU |

## Verification
The summary folding is tried with single sources, each placed where it shows one thing:
- a bank bit on a shortcut position, which must set its copy bit and leave the bank flag clear;
- a bank bit off the shortcut list, which must set only the flag;
- the last shortcut of each bank (bank A bit 19, bank B bit 30), which checks the ordering at the ends.

With every source asserted and fully enabled, the bench confirms that exactly bits 20:0 are set. Partly masked patterns separate the raw source from the enable. Writes carrying mixed 1s and 0s to the set and clear addresses show that 0 bits leave masks untouched. Dropping sources while they stay enabled shows that pending follows the level and is not held.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int BASIC_N   = 8;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int SRC_W     = BASIC_N + NUM_BANKS * BANK_W;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int SC_A_N    = 5;
  localparam int SC_B_N    = 6;
  localparam int FLAG_BASE = BASIC_N;
  localparam int SUM_W     = BASIC_N + NUM_BANKS + SC_A_N + SC_B_N;

  localparam logic [ADDR_W-1:0] OFS_SUMMARY   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND_A    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PEND_B    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RESERVED  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_SET_BASIC = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR_BASIC = 6'h24;

  // Byte offsets of the set / clear words of each peripheral bank
  function automatic logic [ADDR_W-1:0] bank_set_ofs(input int b);
    return (b == 0) ? 6'h10 : 6'h14;
  endfunction

  function automatic logic [ADDR_W-1:0] bank_clr_ofs(input int b);
    return (b == 0) ? 6'h1C : 6'h20;
  endfunction

  // Number of shortcut copies a bank owns in the summary word
  function automatic int sc_count(input int b);
    return (b == 0) ? SC_A_N : SC_B_N;
  endfunction

  // First summary bit holding a shortcut copy of bank b
  function automatic int sc_base(input int b);
    return BASIC_N + NUM_BANKS + ((b == 0) ? 0 : SC_A_N);
  endfunction

  // Bank bit copied into shortcut slot k of bank b
  function automatic int sc_index(input int b, input int k);
    int r;
    r = 0;
    if (b == 0) begin
      case (k)
        0: r = 7;
        1: r = 9;
        2: r = 10;
        3: r = 18;
        default: r = 19;
      endcase
    end else begin
      case (k)
        0: r = 21;
        1: r = 22;
        2: r = 23;
        3: r = 24;
        4: r = 25;
        default: r = 30;
      endcase
    end
    return r;
  endfunction

  // Bits of bank b that have a shortcut and so stay out of its flag
  function automatic logic [BANK_W-1:0] sc_mask(input int b);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int k = 0; k < sc_count(b); k++) m[sc_index(b, k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_bank_pkg::*;
#(
  parameter int                W       = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = 6'h10,
  parameter logic [ADDR_W-1:0] CLR_OFS = 6'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      en
);
  logic set_hit;
  logic clr_hit;

  assign set_hit = we && (addr == SET_OFS);
  assign clr_hit = we && (addr == CLR_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= '0;
    else if (set_hit) en <= en | wdata;
    else if (clr_hit) en <= en & ~wdata;
  end

  p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((en & $past(wdata)) == $past(wdata)));

  p_clr_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((en & $past(wdata)) == '0));

  p_zero_bits_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit || clr_hit) |=> ((en & ~$past(wdata)) == ($past(en) & ~$past(wdata))));

  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(en));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_bank_pkg::*;
(
  input  logic [BASIC_N-1:0]                basic_pend,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_pend,
  output logic [DATA_W-1:0]                 summary
);
  logic [SUM_W-1:0] sum_bits;

  assign sum_bits[BASIC_N-1:0] = basic_pend;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sum_bits[FLAG_BASE + b] = |(bank_pend[b] & ~sc_mask(b));
    for (genvar k = 0; k < sc_count(b); k++) begin : g_sc
      assign sum_bits[sc_base(b) + k] = bank_pend[b][sc_index(b, k)];
    end
  end

  assign summary = {{(DATA_W - SUM_W){1'b0}}, sum_bits};
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SRC_W-1:0]  src_in,
  output logic              cpu_irq
);
  logic [BASIC_N-1:0]                basic_en;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_en;
  logic [BASIC_N-1:0]                basic_pend;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_pend;
  logic [DATA_W-1:0]                 summary;
  logic [SRC_W-1:0]                  en_all;

  irq_mask_bank #(
    .W(BASIC_N), .SET_OFS(OFS_SET_BASIC), .CLR_OFS(OFS_CLR_BASIC)
  ) u_basic_mask (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata[BASIC_N-1:0]), .en(basic_en)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_mask_bank #(
      .W(BANK_W), .SET_OFS(bank_set_ofs(b)), .CLR_OFS(bank_clr_ofs(b))
    ) u_mask (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
      .wdata(reg_wdata[BANK_W-1:0]), .en(bank_en[b])
    );
    assign bank_pend[b] = src_in[BASIC_N + b*BANK_W +: BANK_W] & bank_en[b];
  end

  assign basic_pend = src_in[BASIC_N-1:0] & basic_en;
  assign en_all     = {bank_en, basic_en};

  irq_summary u_summary (
    .basic_pend(basic_pend), .bank_pend(bank_pend), .summary(summary)
  );

  assign cpu_irq = |summary;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_SUMMARY:     reg_rdata = summary;
      OFS_PEND_A:      reg_rdata = bank_pend[0];
      OFS_PEND_B:      reg_rdata = bank_pend[1];
      OFS_SET_BASIC:   reg_rdata = {{(DATA_W - BASIC_N){1'b0}}, basic_en};
      bank_set_ofs(0): reg_rdata = bank_en[0];
      bank_set_ofs(1): reg_rdata = bank_en[1];
      default:         reg_rdata = '0;
    endcase
  end

  // The line rises only for a source that is both asserted and enabled
  p_irq_from_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (|(src_in & en_all)));

  p_upper_summary_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_SUMMARY) |-> (reg_rdata[DATA_W-1:SUM_W] == '0));
endmodule

// File: tb/irq_bank_regs_bench.sv
`timescale 1ns/1ps
module irq_bank_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [71:0] src_in = '0;
  logic        cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  m_en0 = '0;
  logic [31:0] m_en1 = '0;
  logic [31:0] m_en2 = '0;

  logic [31:0] q_exp[$];
  bit          q_kind[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  irq_bank_regs u_irq_bank_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
    .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] model_summary();
    int a_list[5] = '{7, 9, 10, 18, 19};
    int b_list[6] = '{21, 22, 23, 24, 25, 30};
    logic [31:0] pa, pb, s;
    logic [31:0] rest_a, rest_b;
    pa = src_in[39:8] & m_en1;
    pb = src_in[71:40] & m_en2;
    s = '0;
    s[7:0] = src_in[7:0] & m_en0;
    rest_a = pa;
    rest_b = pb;
    foreach (a_list[i]) begin
      s[10 + i] = pa[a_list[i]];
      rest_a[a_list[i]] = 1'b0;
    end
    foreach (b_list[i]) begin
      s[15 + i] = pb[b_list[i]];
      rest_b[b_list[i]] = 1'b0;
    end
    s[8] = (rest_a != 0);
    s[9] = (rest_b != 0);
    return s;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    case (a)
      6'h00:   return model_summary();
      6'h04:   return src_in[39:8] & m_en1;
      6'h08:   return src_in[71:40] & m_en2;
      6'h18:   return {24'h0, m_en0};
      6'h10:   return m_en1;
      6'h14:   return m_en2;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    case (a)
      6'h18: m_en0 = m_en0 | d[7:0];
      6'h24: m_en0 = m_en0 & ~d[7:0];
      6'h10: m_en1 = m_en1 | d;
      6'h1C: m_en1 = m_en1 & ~d;
      6'h14: m_en2 = m_en2 | d;
      6'h20: m_en2 = m_en2 & ~d;
      default: ;
    endcase
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic drive_src(input logic [71:0] v);
    @(negedge clk);
    src_in = v;
  endtask

  task automatic expect_rd(input logic [5:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    q_exp.push_back(model_read(a));
    q_kind.push_back(1'b0);
    q_tag.push_back(tag);
  endtask

  task automatic expect_irq(input string tag);
    @(negedge clk);
    q_exp.push_back({31'h0, (model_summary() != 0)});
    q_kind.push_back(1'b1);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares each queued expectation mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q_exp.size() > 0) begin
        logic [31:0] e, act;
        bit k;
        string t;
        e = q_exp.pop_front(); k = q_kind.pop_front(); t = q_tag.pop_front();
        act = k ? {31'h0, cpu_irq} : reg_rdata;
        checks++;
        if (act !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    src_in = {72{1'b1}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state with every source asserted
    expect_rd(6'h18, "R10 basic enable after reset");
    expect_rd(6'h10, "R10 bank A enable after reset");
    expect_rd(6'h14, "R10 bank B enable after reset");
    expect_rd(6'h00, "R10 summary after reset");
    expect_irq("R10 irq after reset");

    // R2, R5, R9: basic sources
    drive_src({64'h0, 8'hFF});
    wr(6'h18, 32'hFFFF_FFA5);
    expect_rd(6'h18, "R2 basic set readback");
    expect_rd(6'h00, "R5 summary basic bits");
    expect_irq("R9 irq with basic pending");
    wr(6'h18, 32'h0);
    expect_rd(6'h18, "R2 zero write keeps enables");
    wr(6'h24, 32'h05);
    expect_rd(6'h18, "R3 basic clear readback");
    expect_rd(6'h24, "R4 clear address reads zero");
    wr(6'h24, 32'hA0);
    expect_irq("R9 irq drops when all masked");

    // R1, R6, R7: bank A shortcut and flag
    wr(6'h10, 32'hFFFF_FFFF);
    drive_src({32'h0, 32'h0000_0080, 8'h00});
    expect_rd(6'h04, "R1 bank A pending word");
    expect_rd(6'h00, "R7 bank A bit 7 to shortcut");
    drive_src({32'h0, 32'h0008_0000, 8'h00});
    expect_rd(6'h00, "R7 bank A bit 19 last shortcut");
    drive_src({32'h0, 32'h0000_0008, 8'h00});
    expect_rd(6'h00, "R6 bank A flag from bit 3");
    wr(6'h1C, 32'h0000_0008);
    expect_rd(6'h10, "R3 bank A clear readback");
    expect_rd(6'h00, "R3 masked bank A source");

    // R1, R6, R7: bank B
    wr(6'h14, 32'h4000_0001);
    drive_src({32'h4000_0001, 32'h0, 8'h00});
    expect_rd(6'h08, "R1 bank B pending word");
    expect_rd(6'h00, "R7 R6 bank B bit 30 and flag");
    wr(6'h14, 32'hFFFF_FFFF);
    drive_src({32'h0020_0000, 32'h0, 8'h00});
    expect_rd(6'h00, "R7 bank B bit 21 first shortcut");

    // R8: everything on
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFF);
    drive_src({72{1'b1}});
    expect_rd(6'h00, "R8 full summary width");

    // R4: writes to read-only and reserved words
    wr(6'h00, 32'h0);
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h04, 32'h0);
    expect_rd(6'h0C, "R4 reserved reads zero");
    expect_rd(6'h10, "R4 bank A enables unchanged");
    expect_rd(6'h20, "R4 bank B clear reads zero");

    // R1: pending follows level
    drive_src('0);
    expect_rd(6'h00, "R1 summary after sources drop");
    expect_irq("R1 irq after sources drop");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule